// File: doc/BRIEF.md
# Adaptive Decision-Feedback Equalizer with Sign-Data LMS Tap Adaptation

This block cleans inter-symbol interference out of a binary serial data stream. On every accepted sample it removes the contribution of the four previous decisions, each scaled by its own tap weight, from the incoming fixed-point sample. It then slices the equalized value to a level of plus or minus one and forms an error against a target symbol. It uses that error to nudge every tap by a least-mean-squares step. The step is a fixed arithmetic right shift of the error, so the update needs no multiplier.

The target comes from one of two places, selected per symbol. In training mode it is a known reference symbol supplied beside the sample, typically a PRBS9 pattern produced outside the block. In blind mode it is the block's own slicer decision. A freeze input stops adaptation while equalization carries on. The current tap weights are always visible on a flat readback bus.

Samples, taps and the unit level are signed Q2.13: one equals 8192, and a tap spans -32768 to 32767.

Top module: `dfe_lms_engine`

## Requirements
- R1: A synchronous reset clears all four taps to 0, clears `dec_valid`, and sets every stored past decision to -1 (history bit 0).
- R2: For each cycle with `in_valid` high, `dec_valid` is high one cycle later with `dec_out` = 1 exactly when y >= 0. Here y = `sample_in` minus the sum over k of w_k·d(n-1-k), where history bit 1 stands for +1 and bit 0 for -1, and tap k (k = 0 is the most recent decision) sits at `taps_out[16k+15:16k]`. The new decision then becomes the most recent history entry.
- R3: With `train_mode` = 1, `err_out` = y - T, where T = +8192 when `train_sym` = 1 and T = -8192 when it is 0.
- R4: With `train_mode` = 0, `err_out` = y - T, where T = +8192 when the same cycle's decision is 1 and T = -8192 when it is 0.
- R5: With `in_valid` high and `freeze` low, each tap is updated by q = `err_out` >>> 8 (arithmetic shift). Tap k gains +q when d(n-1-k) = +1 and -q when d(n-1-k) = -1. The new tap value appears on `taps_out` in the same cycle as the matching decision.
- R6: A tap update whose exact result falls outside [-32768, 32767] is clamped to the nearer bound instead of wrapping.
- R7: While `freeze` is high, taps keep their value; decisions, errors and the decision history still advance.
- R8: A cycle with `in_valid` low produces no `dec_valid`, changes no tap and leaves the decision history untouched, whatever the sample, symbol and mode inputs hold.
- R9: Given the same sample stream from reset, a blind-mode run whose decisions all equal the training symbols ends with exactly the same taps as a training-mode run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is presented this cycle |
| sample_in | input | 16 | Received sample, signed Q2.13 |
| train_sym | input | 1 | Reference symbol, 1 = +1, 0 = -1 |
| train_mode | input | 1 | 1 = training target, 0 = blind target |
| freeze | input | 1 | Hold all taps |
| dec_valid | output | 1 | Decision and error are valid |
| dec_out | output | 1 | Slicer decision, 1 = +1, 0 = -1 |
| err_out | output | 20 | Signed error y - target |
| taps_out | output | 64 | Four signed Q2.13 taps, tap 0 in the low bits |

## Verification
A PRBS9 symbol stream sent through a four-cursor interference model exercises adaptation under realistic, mixed decision histories, in both training and blind target selection. Near-full-scale samples paired with a reference symbol of the opposite sign drive a large error; with a zero shift this pushes every tap into both clamp bounds, so saturation is distinguished from wrap-around. Frozen and idle stretches with changing inputs show that taps and history move only on accepted, unfrozen samples. Two runs from reset over one sample stream, one training and one blind, show that the two target sources give identical taps when decisions are error-free.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

  typedef enum logic {
    TGT_BLIND = 1'b0,
    TGT_TRAIN = 1'b1
  } target_sel_e;

  // Map a binary symbol to its signed unit level of the given width.
  function automatic logic signed [31:0] sym_level(input logic sym, input int frac);
    logic signed [31:0] one;
    one = 32'sd1 <<< frac;
    return sym ? one : -one;
  endfunction

endpackage

// File: rtl/dfe_feedback_sum.sv
module dfe_feedback_sum #(
  parameter int DW    = 16,
  parameter int NTAPS = 4,
  parameter int SW    = 19
) (
  input  logic [NTAPS*DW-1:0]   taps_flat,
  input  logic [NTAPS-1:0]      hist,
  output logic signed [SW-1:0]  fb
);

  logic signed [SW-1:0] term [NTAPS];

  for (genvar k = 0; k < NTAPS; k++) begin : g_term
    logic signed [SW-1:0] w_ext;
    assign w_ext   = SW'($signed(taps_flat[k*DW +: DW]));
    assign term[k] = hist[k] ? w_ext : -w_ext;
  end

  always_comb begin
    fb = '0;
    for (int k = 0; k < NTAPS; k++) begin
      fb = fb + term[k];
    end
  end

endmodule

// File: rtl/dfe_slicer_err.sv
module dfe_slicer_err
  import dfe_pkg::*;
#(
  parameter int DW   = 16,
  parameter int SW   = 19,
  parameter int EW   = 20,
  parameter int FRAC = 13
) (
  input  logic [DW-1:0]         sample,
  input  logic signed [SW-1:0]  fb,
  input  logic                  train_sym,
  input  target_sel_e           tsel,
  output logic                  dec,
  output logic signed [EW-1:0]  err
);

  localparam logic signed [EW-1:0] UNIT = EW'(1) <<< FRAC;

  logic signed [SW-1:0] y;
  logic                 tgt_sym;
  logic signed [EW-1:0] tgt;

  assign y       = SW'($signed(sample)) - fb;
  assign dec     = ~y[SW-1];
  assign tgt_sym = (tsel == TGT_TRAIN) ? train_sym : dec;
  assign tgt     = tgt_sym ? UNIT : -UNIT;
  assign err     = EW'(y) - tgt;

endmodule

// File: rtl/dfe_tap_bank.sv
module dfe_tap_bank #(
  parameter int DW       = 16,
  parameter int NTAPS    = 4,
  parameter int EW       = 20,
  parameter int MU_SHIFT = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd_en,
  input  logic signed [EW-1:0] err,
  input  logic [NTAPS-1:0]     hist,
  output logic [NTAPS*DW-1:0]  taps_flat
);

  localparam int AW = EW + 1;
  localparam logic signed [AW-1:0] WMAX = AW'((1 <<< (DW-1)) - 1);
  localparam logic signed [AW-1:0] WMIN = -AW'(1 <<< (DW-1));

  logic signed [EW-1:0] step;
  assign step = err >>> MU_SHIFT;

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    logic signed [DW-1:0] w_q;
    logic signed [AW-1:0] w_sum;
    logic signed [DW-1:0] w_next;

    assign w_sum = AW'(w_q) + (hist[k] ? AW'(step) : -AW'(step));

    always_comb begin
      if (w_sum > WMAX)      w_next = WMAX[DW-1:0];
      else if (w_sum < WMIN) w_next = WMIN[DW-1:0];
      else                   w_next = w_sum[DW-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst)         w_q <= '0;
      else if (upd_en) w_q <= w_next;
    end

    assign taps_flat[k*DW +: DW] = w_q;
  end

endmodule

// File: rtl/dfe_lms_engine.sv
module dfe_lms_engine
  import dfe_pkg::*;
#(
  parameter int DW       = 16,
  parameter int NTAPS    = 4,
  parameter int FRAC     = 13,
  parameter int MU_SHIFT = 8,
  localparam int SW      = DW + $clog2(NTAPS) + 1,
  localparam int EW      = SW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [DW-1:0]        sample_in,
  input  logic                 train_sym,
  input  logic                 train_mode,
  input  logic                 freeze,
  output logic                 dec_valid,
  output logic                 dec_out,
  output logic [EW-1:0]        err_out,
  output logic [NTAPS*DW-1:0]  taps_out
);

  logic [NTAPS-1:0]     hist_q;
  logic signed [SW-1:0] fb;
  logic                 dec_c;
  logic signed [EW-1:0] err_c;
  target_sel_e          tsel;

  assign tsel = train_mode ? TGT_TRAIN : TGT_BLIND;

  dfe_feedback_sum #(.DW(DW), .NTAPS(NTAPS), .SW(SW)) u_fb (
    .taps_flat (taps_out),
    .hist      (hist_q),
    .fb        (fb)
  );

  dfe_slicer_err #(.DW(DW), .SW(SW), .EW(EW), .FRAC(FRAC)) u_slice (
    .sample    (sample_in),
    .fb        (fb),
    .train_sym (train_sym),
    .tsel      (tsel),
    .dec       (dec_c),
    .err       (err_c)
  );

  dfe_tap_bank #(.DW(DW), .NTAPS(NTAPS), .EW(EW), .MU_SHIFT(MU_SHIFT)) u_taps (
    .clk       (clk),
    .rst       (rst),
    .upd_en    (in_valid & ~freeze),
    .err       (err_c),
    .hist      (hist_q),
    .taps_flat (taps_out)
  );

  // Decision history: bit 0 holds the most recent decision.
  always_ff @(posedge clk) begin
    if (rst)           hist_q <= '0;
    else if (in_valid) hist_q <= {hist_q[NTAPS-2:0], dec_c};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_out   <= 1'b0;
      err_out   <= '0;
    end else begin
      dec_valid <= in_valid;
      if (in_valid) begin
        dec_out <= dec_c;
        err_out <= err_c;
      end
    end
  end

endmodule

// File: rtl/dfe_lms_checker.sv
module dfe_lms_checker #(
  parameter int DW    = 16,
  parameter int NTAPS = 4,
  parameter int FRAC  = 13,
  parameter int EW    = 20
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 train_sym,
  input logic                 train_mode,
  input logic                 freeze,
  input logic                 dec_valid,
  input logic                 dec_out,
  input logic signed [EW-1:0] err_out,
  input logic [NTAPS*DW-1:0]  taps_out
);

  localparam logic signed [EW-1:0] UP = EW'(1) <<< FRAC;
  localparam logic signed [EW-1:0] UN = -UP;

  // R1: reset leaves taps cleared and no decision pending
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (taps_out == '0) && !dec_valid);

  // R2: every accepted sample yields a decision one cycle later
  a_r2_valid_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> dec_valid);

  // R8: idle cycles produce nothing and touch no tap
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !dec_valid && $stable(taps_out));

  // R7: frozen taps hold
  a_r7_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    (in_valid && freeze) |=> $stable(taps_out));

  // R3: training error plus reference level has the sign of the decision
  a_r3_train_err: assert property (@(posedge clk) disable iff (rst)
    (in_valid && train_mode) |=>
      (dec_out == ((err_out + ($past(train_sym) ? UP : UN)) >= 0)));

  // R4: blind error measured against the decision's own level
  a_r4_blind_err: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !train_mode) |=>
      (dec_out ? (err_out >= UN) : (err_out < UP)));

endmodule

bind dfe_lms_engine dfe_lms_checker #(
  .DW(DW), .NTAPS(NTAPS), .FRAC(FRAC), .EW(EW)
) u_lms_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .train_sym(train_sym),
  .train_mode(train_mode), .freeze(freeze), .dec_valid(dec_valid),
  .dec_out(dec_out), .err_out(err_out), .taps_out(taps_out)
);

// File: tb/tb_dfe_lms_engine.sv
module tb_dfe_lms_engine;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit    d;
    int    e;
    int    w[4];
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, train_sym, train_mode, freeze;
  logic [15:0] sample_in;
  logic        dec_valid, dec_out;
  logic [19:0] err_out;
  logic [63:0] taps_out;

  logic        f_valid, f_ts, f_tm;
  logic [15:0] f_x;
  logic        f_dv, f_dec;
  logic [19:0] f_err;
  logic [63:0] f_taps;

  always #(CLK_PERIOD/2) clk = ~clk;

  dfe_lms_engine dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sample_in(sample_in),
    .train_sym(train_sym), .train_mode(train_mode), .freeze(freeze),
    .dec_valid(dec_valid), .dec_out(dec_out), .err_out(err_out), .taps_out(taps_out)
  );

  dfe_lms_engine #(.MU_SHIFT(0)) dut_fast (
    .clk(clk), .rst(rst), .in_valid(f_valid), .sample_in(f_x),
    .train_sym(f_ts), .train_mode(f_tm), .freeze(1'b0),
    .dec_valid(f_dv), .dec_out(f_dec), .err_out(f_err), .taps_out(f_taps)
  );

  int   n_chk = 0, n_fail = 0;
  exp_t q[$];
  int   mw[4];
  bit   mh[4];
  bit   sh[4];
  bit [8:0] lfsr;

  function automatic int tap_of(input logic [63:0] t, input int k);
    return int'($signed(t[k*16 +: 16]));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 4; k++) begin mw[k] = 0; mh[k] = 0; sh[k] = 0; end
    lfsr = 9'h1FF;
  endtask

  // Reference model built from R2..R6
  task automatic send_raw(input int x, input bit ts, input bit tm, input bit fz, input string tag);
    exp_t it;
    int fb, y, t, st, nw;
    @(negedge clk);
    in_valid = 1'b1; sample_in = 16'(x); train_sym = ts; train_mode = tm; freeze = fz;
    fb = 0;
    for (int k = 0; k < 4; k++) fb += mh[k] ? mw[k] : -mw[k];
    y = x - fb;
    it.d = (y >= 0);
    t = (tm ? ts : it.d) ? 8192 : -8192;
    it.e = y - t;
    st = it.e >>> 8;
    if (!fz) begin
      for (int k = 0; k < 4; k++) begin
        nw = mw[k] + (mh[k] ? st : -st);
        if (nw > 32767) nw = 32767;
        if (nw < -32768) nw = -32768;
        mw[k] = nw;
      end
    end
    for (int k = 3; k > 0; k--) mh[k] = mh[k-1];
    mh[0] = it.d;
    for (int k = 0; k < 4; k++) it.w[k] = mw[k];
    it.tag = tag;
    q.push_back(it);
  endtask

  // Channel with cursors 0.6, 0.15, 0.08, 0.04 on PRBS9 symbols
  task automatic send_prbs(input bit tm, input bit fz, input string tag);
    bit s;
    int x;
    s = lfsr[8] ^ lfsr[4];
    lfsr = {lfsr[7:0], s};
    x = (s ? 4915 : -4915) + (sh[0] ? 1229 : -1229) + (sh[1] ? 655 : -655) + (sh[2] ? 328 : -328);
    sh[3] = sh[2]; sh[2] = sh[1]; sh[1] = sh[0]; sh[0] = s;
    send_raw(x, s, tm, fz, tag);
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && dec_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R2 unexpected dec_valid", 1, 0);
      end else begin
        exp_t it;
        it = q.pop_front();
        chk(dec_out == it.d, {"R2 decision ", it.tag}, int'(dec_out), int'(it.d));
        chk(int'($signed(err_out)) == it.e, {"R3/R4 error ", it.tag},
            int'($signed(err_out)), it.e);
        for (int k = 0; k < 4; k++)
          chk(tap_of(taps_out, k) == it.w[k], {"R5 tap ", it.tag}, tap_of(taps_out, k), it.w[k]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD*150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  int wa[4], wb[4], hold[4];
  bit dec_ok;

  initial begin
    rst = 1'b1; in_valid = 1'b0; sample_in = '0; train_sym = 1'b0; train_mode = 1'b1; freeze = 1'b0;
    f_valid = 1'b0; f_x = '0; f_ts = 1'b0; f_tm = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(taps_out == '0, "R1 taps cleared", int'(taps_out[15:0]), 0);
    chk(dec_valid == 1'b0, "R1 dec_valid low", int'(dec_valid), 0);

    // R6 lower clamp on the unshifted instance
    f_valid = 1'b1; f_x = 16'sd32767; f_ts = 1'b0; f_tm = 1'b1;
    @(negedge clk);
    chk(f_dec == 1'b1, "R2 fast decision n0", int'(f_dec), 1);
    chk(int'($signed(f_err)) == 40959, "R3 fast error n0", int'($signed(f_err)), 40959);
    for (int k = 0; k < 4; k++)
      chk(tap_of(f_taps, k) == -32768, "R6 low clamp", tap_of(f_taps, k), -32768);
    @(negedge clk);
    f_valid = 1'b0;
    chk(f_dec == 1'b0, "R2 fast decision n1", int'(f_dec), 0);
    chk(tap_of(f_taps, 0) == -32768, "R6 clamp tap0 n1", tap_of(f_taps, 0), -32768);
    for (int k = 1; k < 4; k++)
      chk(tap_of(f_taps, k) == -8191, "R5 fast tap n1", tap_of(f_taps, k), -8191);

    // R1 first step uses the -1 history
    send_raw(4096, 1'b1, 1'b1, 1'b0, "R1 first symbol");
    // Training, blind, frozen and large-sample patterns
    for (int i = 0; i < 200; i++) send_prbs(1'b1, 1'b0, "R3 training");
    for (int i = 0; i < 60; i++)  send_prbs(1'b0, 1'b0, "R4 blind");
    for (int i = 0; i < 20; i++)  send_prbs(1'b1, 1'b1, "R7 frozen");
    for (int i = 0; i < 10; i++)  send_raw((i % 2) ? -28000 : 28000, (i % 3) == 0, 1'b1, 1'b0, "R5 large");
    for (int i = 0; i < 10; i++)  send_raw((i % 2) ? 30000 : -30000, 1'b0, 1'b0, 1'b0, "R4 large blind");
    go_idle();
    @(negedge clk);
    for (int k = 0; k < 4; k++) hold[k] = tap_of(taps_out, k);
    // R8 idle with busy inputs
    for (int i = 0; i < 8; i++) begin
      sample_in = 16'(i * 4000 - 16000); train_sym = i[0]; train_mode = i[1];
      @(negedge clk);
      chk(dec_valid == 1'b0, "R8 no dec_valid", int'(dec_valid), 0);
    end
    for (int k = 0; k < 4; k++)
      chk(tap_of(taps_out, k) == hold[k], "R8 taps held", tap_of(taps_out, k), hold[k]);
    send_raw(-3000, 1'b0, 1'b1, 1'b0, "R8 history kept");
    go_idle();
    @(negedge clk);

    // R9 training run then blind run over one stream
    rst = 1'b1; model_reset();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R6 upper clamp on the unshifted instance
    f_valid = 1'b1; f_x = 16'h8000; f_ts = 1'b1; f_tm = 1'b1;
    @(negedge clk);
    f_valid = 1'b0;
    chk(int'($signed(f_err)) == -40960, "R3 fast error high", int'($signed(f_err)), -40960);
    for (int k = 0; k < 4; k++)
      chk(tap_of(f_taps, k) == 32767, "R6 high clamp", tap_of(f_taps, k), 32767);

    for (int i = 0; i < 300; i++) send_prbs(1'b1, 1'b0, "R9 training pass");
    go_idle();
    @(negedge clk);
    for (int k = 0; k < 4; k++) wa[k] = tap_of(taps_out, k);

    rst = 1'b1; model_reset();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    dec_ok = 1'b1;
    for (int i = 0; i < 300; i++) begin
      send_prbs(1'b0, 1'b0, "R9 blind pass");
      if (mh[0] != sh[0]) dec_ok = 1'b0;
    end
    go_idle();
    @(negedge clk);
    chk(dec_ok, "R9 blind decisions error-free", int'(dec_ok), 1);
    for (int k = 0; k < 4; k++) begin
      wb[k] = tap_of(taps_out, k);
      chk(wa[k] == wb[k], "R9 blind equals training", wb[k], wa[k]);
    end
    chk(wa[0] > 600, "R9 tap0 adapted toward first post-cursor", wa[0], 1229);

    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R2 all results seen", q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule